// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every data beat of a memory burst. When a read or write command is accepted, it takes in a start column, a burst-length code and a burst-ordering mode. From the next cycle it presents one column address per clock, along with a beat-valid flag. The final address of the burst also carries a last-beat flag.

Two orderings are supported. In wrap mode the address counts upward and folds back inside the aligned block of burst size. In interleaved mode each beat address is the start address XORed with the beat index. Only the column bits inside the aligned block change. All higher column bits stay at their start value for the whole burst. A new request that arrives on the final beat starts the next burst with no idle cycle. A request that arrives earlier is dropped unless it is marked as interrupting.

Top module: `burst_col_seq`

## Requirements
- R1: `req_bl` selects the burst length: 2'b01 gives 2 beats, 2'b10 gives 4, 2'b11 gives 8, and 2'b00 is treated as 2. A burst presents exactly that many valid beats, then `beat_valid` falls unless a new burst was accepted.
- R2: With `req_ilv`=0 (wrap mode), beat i has low bits (start + i) mod BL. For example, BL=4 from 2 gives 2,3,0,1, and BL=8 from 7 gives 7,0,1,2,3,4,5,6.
- R3: With `req_ilv`=1 (interleaved mode), beat i has low bits start XOR i. For example, BL=8 from 5 gives 5,4,7,6,1,0,3,2.
- R4: For BL=2 both modes give the start column, then the start column with bit 0 inverted.
- R5: Column bits at positions log2(BL) and above equal the start column's bits for every beat of the burst.
- R6: A request accepted at a clock edge shows its first beat in the cycle after that edge, with one new beat on each later cycle.
- R7: `beat_last` is high exactly on the final beat of each burst and never without `beat_valid`.
- R8: A request present during the final beat is accepted, and its first beat follows directly with no idle cycle.
- R9: A request with `req_intr`=0 during a non-final beat is ignored. The running burst continues unchanged.
- R10: A request with `req_intr`=1 during any beat ends the running burst. The new burst's first beat appears in the next cycle.
- R11: Synchronous active-high `rst` clears the beat counter and deasserts `beat_valid` and `beat_last` from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Burst command request |
| req_intr | input | 1 | Request may cut the running burst short |
| req_col | input | COL_W | Start column address |
| req_bl | input | 2 | Burst-length code |
| req_ilv | input | 1 | 0 = wrap ordering, 1 = interleaved ordering |
| beat_valid | output | 1 | A beat address is presented |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one |

## Verification
The bench uses the default column width of 10 bits. With this width the upper field above the largest 8-beat block is 7 bits wide, so nonzero upper patterns can be chosen to expose any carry that leaks out of the burst block. The 3-bit beat counter is fully exercised by the 8-beat cases, in both modes, from several start offsets. All three request timings are covered: accepted on an idle cycle, on the last beat, and mid-burst with and without the interrupt flag.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int MAX_LOG = 3;

    typedef logic [MAX_LOG-1:0] beat_idx_t;

    typedef enum logic [1:0] {
        BLC_RSVD = 2'b00,
        BLC_2    = 2'b01,
        BLC_4    = 2'b10,
        BLC_8    = 2'b11
    } bl_code_e;

    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } order_e;

    typedef struct packed {
        logic      active;
        beat_idx_t cnt;
        logic [1:0] len_log;
        order_e    order;
    } burst_st_t;

    function automatic logic [1:0] len_log_of(input logic [1:0] code);
        case (code)
            BLC_4:   len_log_of = 2'd2;
            BLC_8:   len_log_of = 2'd3;
            default: len_log_of = 2'd1;
        endcase
    endfunction

    function automatic beat_idx_t low_mask(input logic [1:0] len_log);
        logic [3:0] full;
        full = (4'd1 << len_log) - 4'd1;
        low_mask = full[MAX_LOG-1:0];
    endfunction

    function automatic beat_idx_t beat_low(input beat_idx_t start,
                                           input beat_idx_t idx,
                                           input logic [1:0] len_log,
                                           input order_e order);
        beat_idx_t raw;
        beat_idx_t m;
        m   = low_mask(len_log);
        raw = (order == ORD_XOR) ? (start ^ idx) : beat_idx_t'(start + idx);
        beat_low = (start & ~m) | (raw & m);
    endfunction

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_intr,
    input  logic [COL_W-1:0] req_col,
    input  logic [1:0]       req_bl,
    input  logic             req_ilv,
    output burst_st_t        st,
    output logic [COL_W-1:0] start_col,
    output logic             last
);

    burst_st_t st_q;
    logic [COL_W-1:0] col_q;
    logic accept;
    beat_idx_t final_idx;

    assign final_idx = low_mask(st_q.len_log);
    assign last      = st_q.active && (st_q.cnt == final_idx);
    assign accept    = req_valid && (!st_q.active || last || req_intr);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '{active: 1'b0, cnt: '0, len_log: 2'd1, order: ORD_WRAP};
            col_q <= '0;
        end else if (accept) begin
            st_q.active  <= 1'b1;
            st_q.cnt     <= '0;
            st_q.len_log <= len_log_of(req_bl);
            st_q.order   <= order_e'(req_ilv);
            col_q        <= req_col;
        end else if (last) begin
            st_q.active <= 1'b0;
            st_q.cnt    <= '0;
        end else if (st_q.active) begin
            st_q.cnt <= st_q.cnt + 1'b1;
        end
    end

    assign st        = st_q;
    assign start_col = col_q;

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && !last && !req_valid) |=> (st_q.active && st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R11
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!st_q.active && st_q.cnt == '0));

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] start_col,
    input  burst_st_t        st,
    output logic [COL_W-1:0] col
);

    localparam int HI_W = COL_W - MAX_LOG;

    beat_idx_t low;

    assign low = beat_low(start_col[MAX_LOG-1:0], st.cnt, st.len_log, st.order);

    generate
        if (HI_W > 0) begin : g_hi
            assign col = {start_col[COL_W-1:MAX_LOG], low};
        end else begin : g_nohi
            assign col = low[COL_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_intr,
    input  logic [COL_W-1:0] req_col,
    input  logic [1:0]       req_bl,
    input  logic             req_ilv,
    output logic             beat_valid,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_last
);

    burst_st_t        st;
    logic [COL_W-1:0] start_col;
    logic             last;

    bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_intr  (req_intr),
        .req_col   (req_col),
        .req_bl    (req_bl),
        .req_ilv   (req_ilv),
        .st        (st),
        .start_col (start_col),
        .last      (last)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .start_col (start_col),
        .st        (st),
        .col       (beat_col)
    );

    assign beat_valid = st.active;
    assign beat_last  = last;

    // R7
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid);

    // R5
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last && !req_valid) |=> $stable(beat_col[COL_W-1:MAX_LOG]));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_last && req_valid) |=> (beat_valid && beat_col[MAX_LOG-1:0] == $past(req_col[MAX_LOG-1:0])));

endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;

    localparam int COL_W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_intr = 1'b0;
    logic [COL_W-1:0] req_col = '0;
    logic [1:0] req_bl = 2'b01;
    logic req_ilv = 1'b0;
    logic beat_valid;
    logic [COL_W-1:0] beat_col;
    logic beat_last;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_intr(req_intr),
        .req_col(req_col), .req_bl(req_bl), .req_ilv(req_ilv),
        .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last)
    );

    function automatic int bl_len(input logic [1:0] code);
        return (code == 2'b10) ? 4 : (code == 2'b11) ? 8 : 2;
    endfunction

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s, input int len,
                                                input logic ilv, input int i);
        int lo;
        int base;
        lo   = int'(s) % len;
        base = int'(s) - lo;
        if (ilv) return COL_W'(base + (lo ^ i));
        return COL_W'(base + ((lo + i) % len));
    endfunction

    task automatic chk(input string tag, input logic v, input logic [COL_W-1:0] c,
                       input logic l);
        n_chk++;
        if (beat_valid !== v || (v && beat_col !== c) || beat_last !== l) begin
            n_bad++;
            $display("FAIL %s: got v=%0b col=%h last=%0b, expected v=%0b col=%h last=%0b",
                     tag, beat_valid, beat_col, beat_last, v, c, l);
        end
    endtask

    task automatic issue(input logic [COL_W-1:0] c, input logic [1:0] bl, input logic ilv,
                         input logic intr);
        req_valid = 1'b1; req_col = c; req_bl = bl; req_ilv = ilv; req_intr = intr;
    endtask

    task automatic drop();
        req_valid = 1'b0; req_intr = 1'b0;
    endtask

    task automatic run_burst(input string tag, input logic [COL_W-1:0] c,
                             input logic [1:0] bl, input logic ilv);
        int len;
        len = bl_len(bl);
        issue(c, bl, ilv, 1'b0);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 0) drop();
            chk(tag, 1'b1, exp_col(c, len, ilv, i), i == len - 1);
        end
        @(negedge clk);
        chk({tag, " idle after end R1"}, 1'b0, '0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R11 reset state", 1'b0, '0, 1'b0);
    endtask

    task automatic t_wrap4();
        logic [COL_W-1:0] b;
        int seq [4] = '{2, 3, 0, 1};
        b = 10'h124;
        issue(b | 10'h2, 2'b10, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i == 0) drop();
            chk("R2 R5 wrap BL4 from 2", 1'b1, b | COL_W'(seq[i]), i == 3);
        end
        @(negedge clk);
        chk("R1 BL4 ends", 1'b0, '0, 1'b0);
    endtask

    task automatic t_xor8();
        logic [COL_W-1:0] b;
        int seq [8] = '{5, 4, 7, 6, 1, 0, 3, 2};
        b = 10'h2A8;
        issue(b | 10'h5, 2'b11, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 0) drop();
            chk("R3 R5 xor BL8 from 5", 1'b1, b | COL_W'(seq[i]), i == 7);
        end
        @(negedge clk);
        chk("R1 BL8 ends", 1'b0, '0, 1'b0);
    endtask

    task automatic t_wrap8_from7();
        run_burst("R2 R5 wrap BL8 from 7", 10'h3FF, 2'b11, 1'b0);
    endtask

    task automatic t_bl2_both();
        run_burst("R4 BL2 wrap", 10'h0F3, 2'b01, 1'b0);
        run_burst("R4 BL2 xor", 10'h0F3, 2'b01, 1'b1);
        run_burst("R1 code 00 as BL2", 10'h155, 2'b00, 1'b1);
        run_burst("R3 xor BL4 from 3", 10'h20B, 2'b10, 1'b1);
    endtask

    task automatic t_back2back();
        issue(10'h041, 2'b01, 1'b0, 1'b0);
        @(negedge clk);
        drop();
        chk("R6 first beat next cycle", 1'b1, 10'h041, 1'b0);
        @(negedge clk);
        chk("R7 last beat", 1'b1, 10'h040, 1'b1);
        issue(10'h196, 2'b10, 1'b1, 1'b0);
        @(negedge clk);
        drop();
        chk("R8 no gap new beat0", 1'b1, 10'h196, 1'b0);
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            chk("R8 new burst beats", 1'b1, exp_col(10'h196, 4, 1'b1, i), i == 3);
        end
        @(negedge clk);
        chk("R1 idle after second", 1'b0, '0, 1'b0);
    endtask

    task automatic t_ignore();
        issue(10'h0C2, 2'b11, 1'b0, 1'b0);
        @(negedge clk);
        drop();
        chk("R9 beat0", 1'b1, 10'h0C2, 1'b0);
        @(negedge clk);
        chk("R9 beat1", 1'b1, 10'h0C3, 1'b0);
        issue(10'h3F0, 2'b01, 1'b1, 1'b0);
        for (int i = 2; i < 8; i++) begin
            @(negedge clk);
            if (i == 2) drop();
            chk("R9 ignored request", 1'b1, exp_col(10'h0C2, 8, 1'b0, i), i == 7);
        end
        @(negedge clk);
        chk("R9 no late start", 1'b0, '0, 1'b0);
    endtask

    task automatic t_interrupt();
        issue(10'h100, 2'b11, 1'b0, 1'b0);
        @(negedge clk);
        drop();
        @(negedge clk);
        chk("R10 beat1 before intr", 1'b1, 10'h101, 1'b0);
        issue(10'h2E6, 2'b10, 1'b0, 1'b1);
        @(negedge clk);
        drop();
        chk("R10 interrupt beat0", 1'b1, 10'h2E6, 1'b0);
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            chk("R10 interrupt burst", 1'b1, exp_col(10'h2E6, 4, 1'b0, i), i == 3);
        end
        @(negedge clk);
        chk("R10 idle", 1'b0, '0, 1'b0);
    endtask

    task automatic t_reset_mid();
        issue(10'h077, 2'b11, 1'b1, 1'b0);
        @(negedge clk);
        drop();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 reset mid burst", 1'b0, '0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 stays idle", 1'b0, '0, 1'b0);
        run_burst("R11 after reset", 10'h07E, 2'b10, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_wrap4();
        t_xor8();
        t_wrap8_from7();
        t_bl2_both();
        t_back2back();
        t_ignore();
        t_interrupt();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule